// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Read Mode

A 256-word by 36-bit first-in first-out buffer that sits between two unrelated clock domains. One side writes on its own clock, the other reads on a separate clock. Each side sees only flags that are already synchronized to its own clock. The write side sees an input-ready flag. The read side sees a single flag whose meaning depends on a static mode input.

With `fwft_mode` low (standard mode), the read flag means "memory holds data". A word reaches `rd_data` only after an explicit qualified read. With `fwft_mode` high (fall-through mode), the read flag means "a valid word is already on `rd_data`". The first word written into an empty buffer is loaded into the output register without any read request. A qualified read then consumes it.

Both modes use one output-register controller. The controller classifies the memory fill as empty, one word, two words or more, and it is fed by a write pointer that crosses domains in Gray code. The count of consumed words crosses back to the write side in Gray code as well. `fwft_mode` may only change while `rst_n` is low.

Top module: `fifo_dc`

## Requirements
- R1: A word is stored on a rising `wclk` edge only when `wr_cs_n`=0, `wr_dir`=1, `wr_en`=1, `wr_mbx`=0 and `full_ir`=1. Any other combination stores nothing.
- R2: A read takes effect on a rising `rclk` edge only when `rd_cs_n`=0, `rd_dir`=1, `rd_en`=1, `rd_mbx`=0 and `rd_flag`=1. With any control disqualified, `rd_data` and `rd_flag` are unchanged.
- R3: Words leave in the order in which they were stored, with none lost or duplicated, under concurrent writes and reads.
- R4: Fall-through mode (`fwft_mode`=1) behaves as follows when a word is written while `rd_flag` is 0. `rd_flag` stays 0 after the first and second rising `rclk` edges following the write edge. On the third edge, `rd_flag` goes to 1 and the word appears on `rd_data`, with no read request. A qualified read of the last word drives `rd_flag` back to 0.
- R5: In standard mode (`fwft_mode`=0), `rd_flag` is 0 after the first rising `rclk` edge following a write into an empty buffer and 1 after the second. `rd_data` changes only on the edge of a qualified read, and then shows the next stored word.
- R6: While `rd_flag` is 0, read attempts are ignored and `rd_data` keeps its previous word. The one exception is the fall-through load of R4.
- R7: `full_ir` goes to 0 once 256 words are held. In fall-through mode this count includes the word in the output register. While `full_ir` is 0, writes store nothing. `full_ir` returns to 1 after words are read out.
- R8: While reset is applied, `rd_flag`=0, `full_ir`=1 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| fwft_mode | input | 1 | 1 selects fall-through mode, 0 selects standard mode; static outside reset |
| wr_cs_n | input | 1 | Write-port select, active low |
| wr_dir | input | 1 | Write-port direction; must be 1 to write |
| wr_en | input | 1 | Write-port enable, active high |
| wr_mbx | input | 1 | Write-port side-path select; must be 0 to write |
| wr_data | input | 36 | Word to store |
| full_ir | output | 1 | Input ready: 1 when a word can be stored (wclk domain) |
| rd_cs_n | input | 1 | Read-port select, active low |
| rd_dir | input | 1 | Read-port direction; must be 1 to read |
| rd_en | input | 1 | Read-port enable, active high |
| rd_mbx | input | 1 | Read-port side-path select; must be 0 to read |
| rd_data | output | 36 | Registered output word |
| rd_flag | output | 1 | Standard mode: data available. Fall-through mode: output word valid (rclk domain) |

## Verification
Most internal faults in this block show up at `rd_data` or on a flag, usually within a few clock cycles:
- A bad read pointer or a lost load shows as a word out of order, a skipped word or a duplicated word on `rd_data`. The scoreboard compares each qualified read against the queue of accepted writes, so the error appears at the very read where it occurs.
- A wrong synchronizer depth or a wrong output-state decision moves the `rd_flag` edge. This is caught by counting `rclk` edges after a single isolated write: two edges in standard mode and three in fall-through mode.
- A wrong free count on the write side shows as `full_ir` falling one word early or late, or never rising again after the buffer drains.

// File: rtl/fifo_dc_pkg.sv
`timescale 1ns/100ps
package fifo_dc_pkg;

  // Fill classification seen by the output-register controller
  typedef enum logic [1:0] {
    LVL_EMPTY = 2'd0,
    LVL_ONE   = 2'd1,
    LVL_TWO   = 2'd2,
    LVL_MORE  = 2'd3
  } fill_lvl_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    for (int i = 0; i < 32; i++) begin
      b[i] = ^(g >> i);
    end
    return b;
  endfunction

endpackage

// File: rtl/fifo_dc_rst_sync.sv
`timescale 1ns/100ps
module fifo_dc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/fifo_dc_gray_sync.sv
`timescale 1ns/100ps
module fifo_dc_gray_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/fifo_dc_wr_side.sv
`timescale 1ns/100ps
module fifo_dc_wr_side
  import fifo_dc_pkg::*;
#(
  parameter int PTR_W = 9,
  parameter int DEPTH = 256
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             wr_req,
  input  logic [PTR_W-1:0] rfree_bin,
  output logic             wr_fire,
  output logic [PTR_W-1:0] wptr_bin,
  output logic [PTR_W-1:0] wptr_gray,
  output logic             full_ir
);

  logic [PTR_W-1:0] wptr_q, wptr_d;
  logic [PTR_W-1:0] gray_q, gray_d;

  // Held words = written minus consumed (consumed crosses from read side)
  assign full_ir = ((wptr_q - rfree_bin) != PTR_W'(DEPTH));
  assign wr_fire = wr_req & full_ir;

  always_comb begin
    wptr_d = wptr_q;
    if (wr_fire) wptr_d = wptr_q + PTR_W'(1);
    gray_d = PTR_W'(bin2gray(32'(wptr_d)));
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wptr_q <= '0;
      gray_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      gray_q <= gray_d;
    end
  end

  assign wptr_bin  = wptr_q;
  assign wptr_gray = gray_q;

endmodule

// File: rtl/fifo_dc_rd_side.sv
`timescale 1ns/100ps
module fifo_dc_rd_side
  import fifo_dc_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 8,
  parameter int PTR_W  = 9
) (
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              fwft_mode,
  input  logic              rd_req,
  input  logic [PTR_W-1:0]  wsync_bin,
  input  logic [DATA_W-1:0] mem_q,
  output logic [ADDR_W-1:0] raddr,
  output logic [PTR_W-1:0]  rptr_bin,
  output logic [PTR_W-1:0]  free_gray,
  output logic              rd_flag,
  output logic [DATA_W-1:0] rd_data
);

  logic [PTR_W-1:0]  rptr_q, rptr_d;
  logic [PTR_W-1:0]  free_q, free_d;
  logic [PTR_W-1:0]  fgray_q, fgray_d;
  logic [PTR_W-1:0]  in_ram;
  logic              rdy_q, rdy_d;
  logic              rd_fire, load;
  logic [DATA_W-1:0] dout_q, dout_d;
  fill_lvl_e         lvl;

  // Comparator between synchronized write pointer and read pointer
  assign in_ram = wsync_bin - rptr_q;

  always_comb begin
    if (in_ram == '0)                 lvl = LVL_EMPTY;
    else if (in_ram == PTR_W'(1))     lvl = LVL_ONE;
    else if (in_ram == PTR_W'(2))     lvl = LVL_TWO;
    else                              lvl = LVL_MORE;
  end

  assign rd_flag = fwft_mode ? rdy_q : (lvl != LVL_EMPTY);
  assign rd_fire = rd_req & rd_flag;

  always_comb begin
    load  = 1'b0;
    rdy_d = 1'b0;
    if (fwft_mode) begin
      load  = (lvl != LVL_EMPTY) && (!rdy_q || rd_fire);
      rdy_d = load | (rdy_q & ~rd_fire);
    end else begin
      load  = rd_fire;
    end
    rptr_d  = rptr_q + PTR_W'(load);
    free_d  = free_q + PTR_W'(rd_fire);
    fgray_d = PTR_W'(bin2gray(32'(free_d)));
    dout_d  = load ? mem_q : dout_q;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rptr_q  <= '0;
      free_q  <= '0;
      fgray_q <= '0;
      rdy_q   <= 1'b0;
      dout_q  <= '0;
    end else begin
      rptr_q  <= rptr_d;
      free_q  <= free_d;
      fgray_q <= fgray_d;
      rdy_q   <= rdy_d;
      dout_q  <= dout_d;
    end
  end

  assign raddr     = rptr_q[ADDR_W-1:0];
  assign rptr_bin  = rptr_q;
  assign free_gray = fgray_q;
  assign rd_data   = dout_q;

endmodule

// File: rtl/fifo_dc.sv
`timescale 1ns/100ps
module fifo_dc
  import fifo_dc_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              fwft_mode,
  input  logic              wr_cs_n,
  input  logic              wr_dir,
  input  logic              wr_en,
  input  logic              wr_mbx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full_ir,
  input  logic              rd_cs_n,
  input  logic              rd_dir,
  input  logic              rd_en,
  input  logic              rd_mbx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_flag
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;

  logic              wrst_n, rrst_n;
  logic              wr_req, rd_req, wr_fire;
  logic [PTR_W-1:0]  wptr_bin, wptr_gray, wsync_gray, wsync_bin;
  logic [PTR_W-1:0]  rptr_bin, free_gray, rfree_gray, rfree_bin;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] mem [DEPTH];

  fifo_dc_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (
    .clk(wclk), .rst_n(rst_n), .rst_sync_n(wrst_n));
  fifo_dc_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (
    .clk(rclk), .rst_n(rst_n), .rst_sync_n(rrst_n));

  assign wr_req = !wr_cs_n && wr_dir && wr_en && !wr_mbx;
  assign rd_req = !rd_cs_n && rd_dir && rd_en && !rd_mbx;

  fifo_dc_wr_side #(.PTR_W(PTR_W), .DEPTH(DEPTH)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wr_req(wr_req), .rfree_bin(rfree_bin),
    .wr_fire(wr_fire), .wptr_bin(wptr_bin), .wptr_gray(wptr_gray),
    .full_ir(full_ir));

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[wptr_bin[ADDR_W-1:0]] <= wr_data;
  end

  assign mem_q = mem[raddr];

  fifo_dc_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wptr_gray), .q(wsync_gray));
  fifo_dc_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(free_gray), .q(rfree_gray));

  assign wsync_bin = PTR_W'(gray2bin(32'(wsync_gray)));
  assign rfree_bin = PTR_W'(gray2bin(32'(rfree_gray)));

  fifo_dc_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .fwft_mode(fwft_mode), .rd_req(rd_req),
    .wsync_bin(wsync_bin), .mem_q(mem_q), .raddr(raddr), .rptr_bin(rptr_bin),
    .free_gray(free_gray), .rd_flag(rd_flag), .rd_data(rd_data));

endmodule

// File: rtl/fifo_dc_chk.sv
`timescale 1ns/100ps
module fifo_dc_chk #(
  parameter int DATA_W = 36,
  parameter int PTR_W  = 9,
  parameter int DEPTH  = 256
) (
  input logic              wclk,
  input logic              rclk,
  input logic              wrst_n,
  input logic              rrst_n,
  input logic              fwft_mode,
  input logic              rd_cs_n,
  input logic              rd_dir,
  input logic              rd_en,
  input logic              rd_mbx,
  input logic              rd_flag,
  input logic [DATA_W-1:0] rd_data,
  input logic              full_ir,
  input logic [PTR_W-1:0]  wptr_bin,
  input logic [PTR_W-1:0]  rfree_bin,
  input logic [PTR_W-1:0]  wsync_bin,
  input logic [PTR_W-1:0]  rptr_bin
);

  logic rd_ask;
  assign rd_ask = !rd_cs_n && rd_dir && rd_en && !rd_mbx;

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n) (PTR_W'(wptr_bin - rfree_bin) <= PTR_W'(DEPTH))) else $error("held count above depth"); // R7
  AST_FULL_BLOCKS: assert property (@(posedge wclk) disable iff (!wrst_n) !full_ir |=> $stable(wptr_bin)) else $error("write while not ready"); // R7
  AST_NO_UNDERRUN: assert property (@(posedge rclk) disable iff (!rrst_n) (PTR_W'(wsync_bin - rptr_bin) <= PTR_W'(DEPTH))) else $error("read pointer passed write pointer"); // R3
  AST_LOW_HOLDS: assert property (@(posedge rclk) disable iff (!rrst_n) !rd_flag |=> ($stable(rd_data) || (fwft_mode && rd_flag))) else $error("output moved while flag low"); // R6
  AST_STD_READ_ONLY: assert property (@(posedge rclk) disable iff (!rrst_n) (!fwft_mode && !(rd_ask && rd_flag)) |=> $stable(rd_data)) else $error("standard output moved without read"); // R5
  AST_FWFT_AUTOLOAD: assert property (@(posedge rclk) disable iff (!rrst_n) (fwft_mode && !rd_flag && (wsync_bin != rptr_bin)) |=> rd_flag) else $error("fall-through load missing"); // R4

endmodule

bind fifo_dc fifo_dc_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W), .DEPTH(DEPTH)) u_chk (
  .wclk(wclk), .rclk(rclk), .wrst_n(wrst_n), .rrst_n(rrst_n),
  .fwft_mode(fwft_mode), .rd_cs_n(rd_cs_n), .rd_dir(rd_dir), .rd_en(rd_en),
  .rd_mbx(rd_mbx), .rd_flag(rd_flag), .rd_data(rd_data), .full_ir(full_ir),
  .wptr_bin(wptr_bin), .rfree_bin(rfree_bin), .wsync_bin(wsync_bin),
  .rptr_bin(rptr_bin));

// File: tb/tb_fifo_dc.sv
`timescale 1ns/100ps
module tb_fifo_dc;

  localparam real WCLK_PERIOD = 10.0;
  localparam real RCLK_PERIOD = 13.0;
  localparam int  WD_CYCLES   = 100000;

  logic        wclk, rclk, rst_n, fwft_mode;
  logic        wr_cs_n, wr_dir, wr_en, wr_mbx;
  logic [35:0] wr_data;
  logic        full_ir;
  logic        rd_cs_n, rd_dir, rd_en, rd_mbx;
  logic [35:0] rd_data;
  logic        rd_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [35:0] sb [$];

  fifo_dc dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_mode(fwft_mode),
    .wr_cs_n(wr_cs_n), .wr_dir(wr_dir), .wr_en(wr_en), .wr_mbx(wr_mbx),
    .wr_data(wr_data), .full_ir(full_ir),
    .rd_cs_n(rd_cs_n), .rd_dir(rd_dir), .rd_en(rd_en), .rd_mbx(rd_mbx),
    .rd_data(rd_data), .rd_flag(rd_flag));

  // Edges never coincide: wclk rises at 5+10k, rclk at 6.5+13k
  initial wclk = 1'b0;
  always #(WCLK_PERIOD/2.0) wclk = ~wclk;
  initial rclk = 1'b0;
  always #(RCLK_PERIOD/2.0) rclk = ~rclk;

  task automatic chk(input bit ok, input string req, input logic [35:0] act,
                     input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_test();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Driver: pushes a word into the scoreboard when the write will be accepted
  task automatic wr_word(input logic [35:0] d, input logic cs_n = 1'b0,
                         input logic dir = 1'b1, input logic en = 1'b1,
                         input logic mbx = 1'b0);
    @(posedge wclk); #1;
    wr_cs_n = cs_n; wr_dir = dir; wr_en = en; wr_mbx = mbx; wr_data = d;
    @(negedge wclk);
    if (!cs_n && dir && en && !mbx && full_ir) sb.push_back(d);
  endtask

  task automatic wr_idle();
    @(posedge wclk); #1;
    wr_en = 1'b0; wr_cs_n = 1'b1;
  endtask

  task automatic rd_burst(input int n);
    @(posedge rclk); #1;
    rd_cs_n = 1'b0; rd_dir = 1'b1; rd_en = 1'b1; rd_mbx = 1'b0;
    repeat (n) @(posedge rclk);
    #1;
    rd_en = 1'b0; rd_cs_n = 1'b1;
  endtask

  task automatic rd_bad(input logic cs_n, input logic dir, input logic en,
                        input logic mbx);
    @(posedge rclk); #1;
    rd_cs_n = cs_n; rd_dir = dir; rd_en = en; rd_mbx = mbx;
    repeat (2) @(posedge rclk);
    #1;
    rd_en = 1'b0; rd_cs_n = 1'b1; rd_mbx = 1'b0; rd_dir = 1'b1;
  endtask

  task automatic rwait(input int n);
    repeat (n) @(posedge rclk);
    #2;
  endtask

  // Isolated write into an empty buffer, then count rclk edges
  task automatic wr_latency(input logic [35:0] d, input bit fwft);
    @(posedge wclk); #1;
    wr_cs_n = 1'b0; wr_dir = 1'b1; wr_en = 1'b1; wr_mbx = 1'b0; wr_data = d;
    @(negedge wclk);
    if (full_ir) sb.push_back(d);
    @(posedge wclk);
    fork
      begin #1; wr_en = 1'b0; wr_cs_n = 1'b1; end
    join_none
    @(posedge rclk); #0.3;
    chk(rd_flag == 1'b0, fwft ? "R4 edge1 flag" : "R5 edge1 flag", 36'(rd_flag), 36'd0);
    @(posedge rclk); #0.3;
    if (fwft) begin
      chk(rd_flag == 1'b0, "R4 edge2 flag", 36'(rd_flag), 36'd0);
      @(posedge rclk); #0.3;
      chk(rd_flag == 1'b1, "R4 edge3 flag", 36'(rd_flag), 36'd1);
      chk(rd_data == d, "R4 edge3 data without read", rd_data, d);
    end else begin
      chk(rd_flag == 1'b1, "R5 edge2 flag", 36'(rd_flag), 36'd1);
    end
  endtask

  // Monitor: pops the scoreboard on each qualified read
  logic        m_f, m_r, m_m;
  logic [35:0] m_d, m_exp, m_got;
  initial begin
    forever begin
      @(negedge rclk);
      m_f = rd_flag;
      m_r = !rd_cs_n && rd_dir && rd_en && !rd_mbx;
      m_d = rd_data;
      m_m = fwft_mode;
      @(posedge rclk); #2;
      if (m_f && m_r) begin
        m_got = m_m ? m_d : rd_data;
        if (sb.size() == 0) begin
          chk(1'b0, "R3 read with empty scoreboard", m_got, 36'd0);
        end else begin
          m_exp = sb.pop_front();
          chk(m_got == m_exp, "R3 order", m_got, m_exp);
        end
      end
    end
  end

  initial begin
    #(WD_CYCLES * WCLK_PERIOD);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 36'd1, 36'd0);
      finish_test();
    end
  end

  initial begin
    rst_n = 1'b0; fwft_mode = 1'b0;
    wr_cs_n = 1'b1; wr_dir = 1'b1; wr_en = 1'b0; wr_mbx = 1'b0; wr_data = '0;
    rd_cs_n = 1'b1; rd_dir = 1'b1; rd_en = 1'b0; rd_mbx = 1'b0;
    repeat (3) @(posedge wclk);
    #1;
    chk(rd_flag == 1'b0, "R8 flag in reset", 36'(rd_flag), 36'd0);
    chk(full_ir == 1'b1, "R8 ready in reset", 36'(full_ir), 36'd1);
    chk(rd_data == '0, "R8 data in reset", rd_data, 36'd0);
    rst_n = 1'b1;
    rwait(4);

    // ---------------- standard mode ----------------
    rd_burst(4);
    rwait(1);
    chk(rd_data == '0 && rd_flag == 1'b0, "R6 read on empty ignored", rd_data, 36'd0);

    wr_latency(36'h0_1234_5678, 1'b0);
    rwait(3);
    chk(rd_data == '0, "R5 no data before read", rd_data, 36'd0);
    rd_burst(1);
    rwait(1);
    chk(rd_flag == 1'b0, "R5 flag after last read", 36'(rd_flag), 36'd0);
    chk(rd_data == 36'h0_1234_5678, "R6 data held after read", rd_data, 36'h0_1234_5678);

    // R1: disqualified writes must not be stored
    wr_word(36'hA_AAAA_0001, 1'b1, 1'b1, 1'b1, 1'b0);
    wr_word(36'hA_AAAA_0002, 1'b0, 1'b0, 1'b1, 1'b0);
    wr_word(36'hA_AAAA_0003, 1'b0, 1'b1, 1'b0, 1'b0);
    wr_word(36'hA_AAAA_0004, 1'b0, 1'b1, 1'b1, 1'b1);
    wr_word(36'h5_0000_000E);
    wr_idle();
    rwait(4);
    rd_burst(4);
    rwait(2);
    chk(sb.size() == 0 && rd_flag == 1'b0, "R1 only qualified word stored",
        36'(rd_flag), 36'd0);

    // R2: disqualified reads leave output and flag alone
    wr_word(36'h6_0000_0F0F);
    wr_word(36'h6_0000_0A0A);
    wr_idle();
    rwait(4);
    rd_bad(1'b1, 1'b1, 1'b1, 1'b0);
    rd_bad(1'b0, 1'b0, 1'b1, 1'b0);
    rd_bad(1'b0, 1'b1, 1'b0, 1'b0);
    rd_bad(1'b0, 1'b1, 1'b1, 1'b1);
    rwait(1);
    chk(rd_data == 36'h5_0000_000E, "R2 data unchanged", rd_data, 36'h5_0000_000E);
    chk(rd_flag == 1'b1, "R2 flag unchanged", 36'(rd_flag), 36'd1);
    rd_burst(4);
    rwait(2);

    // R3: concurrent stream
    fork
      begin
        for (int i = 0; i < 40; i++) wr_word(36'(i * 36'h1_0101 + 36'h7));
        wr_idle();
      end
      rd_burst(70);
    join
    rd_burst(8);
    rwait(2);
    chk(sb.size() == 0, "R3 standard stream drained", 36'(sb.size()), 36'd0);

    // ---------------- fall-through mode ----------------
    rst_n = 1'b0;
    #3;
    fwft_mode = 1'b1;
    repeat (2) @(posedge wclk);
    #1;
    chk(rd_flag == 1'b0 && rd_data == '0, "R8 reset clears output", rd_data, 36'd0);
    rst_n = 1'b1;
    rwait(4);

    wr_latency(36'h9_8765_4321, 1'b1);
    rd_burst(1);
    rwait(1);
    chk(rd_flag == 1'b0, "R4 flag low after last read", 36'(rd_flag), 36'd0);
    rd_burst(3);
    rwait(1);
    chk(rd_data == 36'h9_8765_4321, "R6 held in fall-through", rd_data, 36'h9_8765_4321);

    // R7: fill to 256 including the output-register word
    for (int i = 0; i < 255; i++) wr_word(36'(36'hC_0000_0000 + i));
    wr_idle();
    repeat (5) @(posedge wclk);
    #1;
    chk(full_ir == 1'b1, "R7 ready at 255 words", 36'(full_ir), 36'd1);
    wr_word(36'hC_0000_00FF);
    wr_idle();
    chk(full_ir == 1'b0, "R7 not ready at 256 words", 36'(full_ir), 36'd0);
    wr_word(36'hD_EAD0_0000);
    wr_idle();
    rd_burst(264);
    rwait(2);
    chk(sb.size() == 0 && rd_flag == 1'b0, "R7 write while full ignored",
        36'(sb.size()), 36'd0);
    repeat (4) @(posedge wclk);
    #1;
    chk(full_ir == 1'b1, "R7 ready after drain", 36'(full_ir), 36'd1);

    // R3 concurrent stream in fall-through mode
    fork
      begin
        for (int i = 0; i < 40; i++) wr_word(36'(36'hE_0000_0000 ^ (i * 36'h3_1313)));
        wr_idle();
      end
      rd_burst(70);
    join
    rd_burst(8);
    rwait(2);
    chk(sb.size() == 0, "R3 fall-through stream drained", 36'(sb.size()), 36'd0);

    finish_test();
  end

endmodule